// File: doc/BRIEF.md
# I2C Slave Address Alias Remapper

This block sits on the I2C path of a serial-link bridge. It receives the address byte of each transaction that a local I2C master starts, as presented by an I2C slave front end at the moment of the address acknowledge. It decides whether the transaction should be carried to the far side of the link, and which address byte the remote bus should see.

Two operating modes are chosen by a static strap. In camera mode, an alias table of up to eight entries is searched. Each entry pairs a match address with the index address that goes to the remote slave. In display mode, the table is ignored. The incoming address is instead compared against a far-end device register and a remote target register, and it is forwarded unchanged.

Whenever a transaction is forwarded, the block asks the front end to stretch SCL until the remote side reports completion. Registers are loaded and read back through a plain write/read port.

Top module: `i2c_alias_remap`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs `fwd_req`, `hit`, `stretch`, `hit_idx`, `xlat_byte` and `reg_rdata` are all zero, and every register reads back as zero.
- R2: A write with `reg_we` high stores `reg_wdata[6:0]` at `reg_addr`. The register map is: offset 0x06 holds the far-end device address; offset 0x07 holds the remote target address; offsets 0x10+i hold the match address of entry i; offsets 0x18+i hold the index address of entry i. `reg_rdata` shows `{1'b0, value}` of the register at `reg_addr` one cycle later, and an unmapped offset reads as 0.
- R3: In camera mode (`mode_cam`=1), when `addr_byte[7:1]` equals the match address of an enabled entry and `addr_stb` is high, the next cycle shows the following. `fwd_req` is high for exactly one cycle, `hit` is 1, `hit_idx` is that entry's number, and `xlat_byte` is `{index address, addr_byte[0]}`.
- R4: When several enabled entries match, the lowest-numbered entry is the one reported and used.
- R5: An entry whose match address is zero is disabled and never matches, not even an incoming address of zero.
- R6: In camera mode, the device and target registers have no effect. An address equal to either of them and to no table entry is not forwarded.
- R7: In display mode (`mode_cam`=0), an address equal to a nonzero device or target register is forwarded. In that case `hit` is 1, `hit_idx` is 0 and `xlat_byte` equals `addr_byte`. The alias table is ignored.
- R8: An address that matches nothing gives `fwd_req`=0, `hit`=0, `hit_idx`=0 and `xlat_byte`=`addr_byte`, and it does not raise `stretch`.
- R9: `stretch` rises together with `fwd_req` and stays high until a `remote_done` pulse has been seen. After that pulse, `stretch` falls at the first later clock edge at which `scl_low` is high. Without `scl_low`, it stays high.
- R10: `hit`, `hit_idx` and `xlat_byte` keep their values until the next `addr_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cam | input | 1 | Static mode strap: 1 camera (alias table), 0 display (two fixed registers) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register offset for write and read |
| reg_wdata | input | 8 | Write data; bits [6:0] are stored |
| reg_rdata | output | 8 | Registered read data |
| addr_stb | input | 1 | Address byte valid, one cycle at address acknowledge |
| addr_byte | input | 8 | Received address byte: [7:1] address, [0] read/write |
| scl_low | input | 1 | High while the local SCL line is in its low phase |
| remote_done | input | 1 | One-cycle pulse: remote side finished its response |
| fwd_req | output | 1 | One-cycle request to forward the transaction |
| hit | output | 1 | Last address matched |
| hit_idx | output | 3 | Table entry that matched (camera mode) |
| xlat_byte | output | 8 | Address byte to place on the remote bus |
| stretch | output | 1 | Request to hold SCL low |

## Verification
The bench builds the block with its default eight-entry table and a five-bit register offset. With these values, every alias slot and both display-mode registers can be reached through the normal port, and the whole priority chain, from entry 0 to entry 7, is covered. Random tables are seeded with duplicated and zeroed match addresses, so that both the lowest-entry rule and the disabled-entry rule occur often. Directed runs cover the stretch release with and without the SCL low phase.

// File: rtl/i2c_alias_pkg.sv
package i2c_alias_pkg;
  localparam int REG_AW = 5;
  localparam int A7_W   = 7;
  typedef logic [A7_W-1:0] addr7_t;
  localparam logic [REG_AW-1:0] OFS_DEV   = 5'h06;
  localparam logic [REG_AW-1:0] OFS_TGT   = 5'h07;
  localparam logic [REG_AW-1:0] OFS_MATCH = 5'h10;
  localparam logic [REG_AW-1:0] OFS_INDEX = 5'h18;
endpackage

// File: rtl/alias_regs.sv
module alias_regs
  import i2c_alias_pkg::*;
#(
  parameter int N_ALIAS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [REG_AW-1:0]        addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [N_ALIAS-1:0][A7_W-1:0] match_tab,
  output logic [N_ALIAS-1:0][A7_W-1:0] index_tab,
  output addr7_t                   dev_addr,
  output addr7_t                   tgt_addr
);
  localparam int MB = int'(OFS_MATCH);
  localparam int IB = int'(OFS_INDEX);

  for (genvar i = 0; i < N_ALIAS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        match_tab[i] <= '0;
        index_tab[i] <= '0;
      end else if (we) begin
        if (int'(addr) == MB + i) match_tab[i] <= wdata[A7_W-1:0];
        if (int'(addr) == IB + i) index_tab[i] <= wdata[A7_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr <= '0;
      tgt_addr <= '0;
    end else if (we) begin
      if (addr == OFS_DEV) dev_addr <= wdata[A7_W-1:0];
      if (addr == OFS_TGT) tgt_addr <= wdata[A7_W-1:0];
    end
  end

  addr7_t rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == OFS_DEV) rd_mux = dev_addr;
    if (addr == OFS_TGT) rd_mux = tgt_addr;
    for (int i = 0; i < N_ALIAS; i++) begin
      if (int'(addr) == MB + i) rd_mux = match_tab[i];
      if (int'(addr) == IB + i) rd_mux = index_tab[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {1'b0, rd_mux};
  end
endmodule

// File: rtl/alias_lookup.sv
module alias_lookup
  import i2c_alias_pkg::*;
#(
  parameter int N_ALIAS = 8,
  localparam int IDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1
) (
  input  logic                         mode_cam,
  input  addr7_t                       in_addr,
  input  logic [N_ALIAS-1:0][A7_W-1:0] match_tab,
  input  logic [N_ALIAS-1:0][A7_W-1:0] index_tab,
  input  addr7_t                       dev_addr,
  input  addr7_t                       tgt_addr,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx,
  output addr7_t                       out_addr
);
  logic [N_ALIAS-1:0] eq;

  for (genvar i = 0; i < N_ALIAS; i++) begin : g_cmp
    assign eq[i] = (match_tab[i] != '0) && (match_tab[i] == in_addr);
  end

  logic disp_hit;
  assign disp_hit = ((dev_addr != '0) && (dev_addr == in_addr)) ||
                    ((tgt_addr != '0) && (tgt_addr == in_addr));

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    out_addr = in_addr;
    if (mode_cam) begin
      for (int i = N_ALIAS - 1; i >= 0; i--) begin
        if (eq[i]) begin
          hit      = 1'b1;
          idx      = IDX_W'(i);
          out_addr = index_tab[i];
        end
      end
    end else begin
      hit = disp_hit;
    end
  end
endmodule

// File: rtl/stretch_ctrl.sv
module stretch_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  input  logic scl_low,
  output logic stretch
);
  logic release_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stretch      <= 1'b0;
      release_pend <= 1'b0;
    end else if (start) begin
      stretch      <= 1'b1;
      release_pend <= 1'b0;
    end else if (stretch && release_pend && scl_low) begin
      stretch      <= 1'b0;
      release_pend <= 1'b0;
    end else if (stretch && done) begin
      release_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_alias_remap.sv
module i2c_alias_remap
  import i2c_alias_pkg::*;
#(
  parameter int N_ALIAS = 8,
  localparam int IDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_cam,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              addr_stb,
  input  logic [7:0]        addr_byte,
  input  logic              scl_low,
  input  logic              remote_done,
  output logic              fwd_req,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [7:0]        xlat_byte,
  output logic              stretch
);
  logic [N_ALIAS-1:0][A7_W-1:0] match_tab, index_tab;
  addr7_t dev_addr, tgt_addr, out_addr;
  logic lk_hit;
  logic [IDX_W-1:0] lk_idx;

  alias_regs #(.N_ALIAS(N_ALIAS)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .match_tab(match_tab), .index_tab(index_tab),
    .dev_addr(dev_addr), .tgt_addr(tgt_addr)
  );

  alias_lookup #(.N_ALIAS(N_ALIAS)) u_lookup (
    .mode_cam(mode_cam), .in_addr(addr_byte[7:1]),
    .match_tab(match_tab), .index_tab(index_tab),
    .dev_addr(dev_addr), .tgt_addr(tgt_addr),
    .hit(lk_hit), .idx(lk_idx), .out_addr(out_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_req   <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
      xlat_byte <= '0;
    end else begin
      fwd_req <= addr_stb && lk_hit;
      if (addr_stb) begin
        hit       <= lk_hit;
        hit_idx   <= lk_idx;
        xlat_byte <= {out_addr, addr_byte[0]};
      end
    end
  end

  stretch_ctrl u_stretch (
    .clk(clk), .rst(rst), .start(addr_stb && lk_hit),
    .done(remote_done), .scl_low(scl_low), .stretch(stretch)
  );
endmodule

// File: rtl/i2c_alias_remap_chk.sv
module i2c_alias_remap_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_cam,
  input logic             addr_stb,
  input logic [7:0]       addr_byte,
  input logic             scl_low,
  input logic             fwd_req,
  input logic             hit,
  input logic [IDX_W-1:0] hit_idx,
  input logic [7:0]       xlat_byte,
  input logic             stretch
);
  p_fwd_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_req |-> $past(addr_stb));

  p_rw_bit_kept_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_req |-> (xlat_byte[0] == $past(addr_byte[0])));

  p_fwd_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (fwd_req && !addr_stb) |=> !fwd_req);

  p_display_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (fwd_req && !mode_cam) |-> (xlat_byte == $past(addr_byte) && hit_idx == '0));

  p_fwd_means_hit_r8: assert property (@(posedge clk) disable iff (rst)
    fwd_req |-> hit);

  p_stretch_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stretch) |-> fwd_req);

  p_stretch_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(stretch) |-> $past(scl_low));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !addr_stb |=> ($stable(hit) && $stable(hit_idx) && $stable(xlat_byte)));
endmodule

bind i2c_alias_remap i2c_alias_remap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mode_cam(mode_cam), .addr_stb(addr_stb),
  .addr_byte(addr_byte), .scl_low(scl_low), .fwd_req(fwd_req), .hit(hit),
  .hit_idx(hit_idx), .xlat_byte(xlat_byte), .stretch(stretch)
);

// File: tb/tb_i2c_alias_remap.sv
module tb_i2c_alias_remap;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_cam = 1'b1;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       addr_stb = 1'b0;
  logic [7:0] addr_byte = '0;
  logic       scl_low = 1'b1;
  logic       remote_done = 1'b0;
  logic       fwd_req, hit, stretch;
  logic [2:0] hit_idx;
  logic [7:0] xlat_byte;

  int n_chk = 0;
  int n_bad = 0;

  logic [6:0] m_match [N];
  logic [6:0] m_index [N];
  logic [6:0] m_dev, m_tgt;

  always #2.5 clk = ~clk;

  i2c_alias_remap #(.N_ALIAS(N)) dut (
    .clk(clk), .rst(rst), .mode_cam(mode_cam), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_stb(addr_stb), .addr_byte(addr_byte), .scl_low(scl_low),
    .remote_done(remote_done), .fwd_req(fwd_req), .hit(hit),
    .hit_idx(hit_idx), .xlat_byte(xlat_byte), .stretch(stretch)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [6:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = {1'b1, d};
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 5'h06) m_dev = d;
    else if (a == 5'h07) m_tgt = d;
    else if (a >= 5'h10 && a < 5'h18) m_match[a - 5'h10] = d;
    else if (a >= 5'h18) m_index[a - 5'h18] = d;
  endtask

  function automatic logic [6:0] exp_reg(logic [4:0] a);
    if (a == 5'h06) return m_dev;
    if (a == 5'h07) return m_tgt;
    if (a >= 5'h10 && a < 5'h18) return m_match[a - 5'h10];
    if (a >= 5'h18) return m_index[a - 5'h18];
    return 7'd0;
  endfunction

  task automatic rd_check(logic [4:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check("R2 readback", reg_rdata, {1'b0, exp_reg(a)});
  endtask

  // expected {hit, idx, xlat}
  function automatic logic [11:0] model(logic [7:0] b);
    logic [6:0] a7;
    a7 = b[7:1];
    if (mode_cam) begin
      for (int i = 0; i < N; i++)
        if (m_match[i] != 0 && m_match[i] == a7)
          return {1'b1, 3'(i), m_index[i], b[0]};
      return {1'b0, 3'd0, b};
    end
    if ((m_dev != 0 && m_dev == a7) || (m_tgt != 0 && m_tgt == a7))
      return {1'b1, 3'd0, b};
    return {1'b0, 3'd0, b};
  endfunction

  task automatic release_bus();
    @(negedge clk); remote_done = 1'b1; scl_low = 1'b1;
    @(negedge clk); remote_done = 1'b0;
    @(negedge clk);
  endtask

  // sends one address, checks results, R3 R7 R8 R9 R10
  task automatic send(logic [7:0] b, string req);
    logic [11:0] e;
    e = model(b);
    @(negedge clk);
    addr_stb = 1'b1; addr_byte = b;
    @(negedge clk);
    addr_stb = 1'b0; addr_byte = ~b;
    check({req, " fwd_req"}, fwd_req, e[11]);
    check({req, " hit"}, hit, e[11]);
    check({req, " hit_idx"}, hit_idx, e[10:8]);
    check({req, " xlat_byte"}, xlat_byte, e[7:0]);
    check({req, " R9 stretch"}, stretch, e[11]);
    @(negedge clk);
    check("R3 fwd_req single pulse", fwd_req, 0);
    check("R10 xlat held", xlat_byte, e[7:0]);
    if (e[11]) begin
      release_bus();
      check("R9 released", stretch, 0);
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_match[i] = 0; m_index[i] = 0; end
    m_dev = 0; m_tgt = 0;
    repeat (3) @(negedge clk);
    check("R1 fwd_req in reset", fwd_req, 0);
    check("R1 stretch in reset", stretch, 0);
    check("R1 xlat in reset", {hit, hit_idx, xlat_byte}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", reg_rdata, 0);
    rd_check(5'h12);
    rd_check(5'h06);

    // R2 register map
    wr(5'h06, 7'h71); wr(5'h07, 7'h58);
    for (int i = 0; i < N; i++) begin
      wr(5'(16 + i), 7'(8'h20 + i));
      wr(5'(24 + i), 7'(8'h40 + i));
    end
    rd_check(5'h06); rd_check(5'h07); rd_check(5'h13); rd_check(5'h1D);
    rd_check(5'h02); // unmapped -> 0

    // camera directed: 0xA2 -> 0xA0 style alias (R3)
    wr(5'h10, 7'h51); wr(5'h18, 7'h50);
    send(8'hA2, "R3 alias");
    send(8'hA3, "R3 alias read bit");
    // R4 lowest wins: entries 2 and 5 both match 0x33
    wr(5'h12, 7'h33); wr(5'h15, 7'h33);
    send({7'h33, 1'b0}, "R4 priority");
    check("R4 idx is 2", hit_idx, 2);
    // R5 zero entry disabled
    wr(5'h13, 7'h00);
    send(8'h00, "R5 zero disabled");
    send(8'h01, "R5 zero disabled rd");
    // R6 dev/tgt ignored in camera mode
    send({7'h71, 1'b0}, "R6 dev ignored");
    send({7'h58, 1'b1}, "R6 tgt ignored");
    send(8'hFE, "R8 miss");

    // R9 directed: no release without scl_low
    send({7'h33, 1'b1}, "R9 setup");
    @(negedge clk); addr_stb = 1'b1; addr_byte = {7'h33, 1'b0}; scl_low = 1'b0;
    @(negedge clk); addr_stb = 1'b0;
    check("R9 stretch set", stretch, 1);
    repeat (3) @(negedge clk);
    check("R9 held without done", stretch, 1);
    remote_done = 1'b1;
    @(negedge clk); remote_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 held until scl low", stretch, 1);
    scl_low = 1'b1;
    @(negedge clk);
    check("R9 released in scl low", stretch, 0);
    // done while scl_low already high: falls one edge later
    @(negedge clk); addr_stb = 1'b1;
    @(negedge clk); addr_stb = 1'b0; remote_done = 1'b1;
    @(negedge clk); remote_done = 1'b0;
    check("R9 still held at done edge", stretch, 1);
    @(negedge clk);
    check("R9 released next edge", stretch, 0);

    // random camera
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < N; i++) begin
        logic [6:0] v;
        v = 7'($urandom);
        if ($urandom_range(3) == 0) v = 0;
        if ($urandom_range(3) == 0) v = m_match[0];
        wr(5'(16 + i), v);
        wr(5'(24 + i), 7'($urandom));
      end
      for (int k = 0; k < 20; k++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if ($urandom_range(1) == 0) b[7:1] = m_match[$urandom_range(N - 1)];
        send(b, "R3 random camera");
      end
    end

    // display mode R7
    mode_cam = 1'b0;
    repeat (2) @(negedge clk);
    wr(5'h06, 7'h22); wr(5'h07, 7'h3C);
    wr(5'h10, 7'h11);
    send({7'h22, 1'b0}, "R7 dev");
    send({7'h3C, 1'b1}, "R7 tgt");
    send({7'h11, 1'b0}, "R7 table ignored");
    wr(5'h07, 7'h00);
    send(8'h00, "R7 zero tgt");
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      case ($urandom_range(2))
        0: b[7:1] = m_dev;
        1: b[7:1] = m_match[$urandom_range(N - 1)];
        default: ;
      endcase
      send(b, "R7 random display");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule